// File: doc/BRIEF.md
# Line Interface Reset and Calibration Sequencer

This block produces the internal reset and start-up sequence for the control plane of a line interface. It has two ways to request a reset. In pin-controlled mode, the two loopback control inputs must both be high for a minimum number of system clock cycles. The reset then fires in the cycle where that joint-high condition ends. In host mode, one control write that sets both loopback bits starts a reset at once.

A reset, like power-up, drives four outputs. It gives a one-cycle register-clear pulse and a one-cycle loss-of-signal set pulse. It holds the oscillator at its centre frequency. It then starts a calibration phase.

At power-up the block waits a programmable number of cycles after the power-good indication before it starts this sequence. The calibration phase keeps a busy flag high. The phase ends when a calibration-done indication arrives while reference-clock activity is present. If no such indication arrives within a programmable limit, the phase ends and a sticky timeout flag is raised. All durations are counted in system clock cycles.

Top module: `li_reset_sequencer`

## Requirements
- R1: While `rst_n` is low (synchronous, active low), `cal_busy`, `reg_clear`, `los_set` and `cal_timeout` are 0 and `osc_centre` is 1.
- R2: With power good low, the block stays idle with `osc_centre` high. After `pwr_good` is first seen high, `reg_clear` rises exactly `PWR_DELAY_CYC + 1` cycles later, and `osc_centre` stays high through that wait.
- R3: In pin mode (`host_mode` = 0), holding `lb_pin_a` and `lb_pin_b` both high for at least `REQ_MIN_CYC` consecutive sampled cycles requests a reset. The reset begins in the cycle where either input is first seen low, and nothing fires while both are still held.
- R4: A joint-high period shorter than `REQ_MIN_CYC` is ignored. The width count restarts from zero whenever either pin is low, and a single pin held high never requests a reset.
- R5: In host mode (`host_mode` = 1), a cycle with `wr_stb` = 1 and both `wr_lb_a` and `wr_lb_b` = 1 starts a reset in the next cycle. A write with only one of the bits set does nothing. Writes in pin mode do nothing. The loopback pins are ignored in host mode.
- R6: A reset produces `reg_clear` and `los_set` high together for exactly one cycle, with `osc_centre` high in that cycle. `cal_busy` is high from the following cycle.
- R7: During calibration, `cal_done` is accepted only while `ref_clk_ok` is 1. `cal_busy` falls in the cycle after it is accepted.
- R8: If calibration is not completed, `cal_busy` stays high for exactly `CAL_LIMIT_CYC` cycles. `cal_timeout` then rises as `cal_busy` falls. It stays high until the next calibration starts.
- R9: Whenever `pwr_good` is seen low, the block returns to idle on the next cycle: `cal_busy` goes to 0 and `osc_centre` goes to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Supply is above its operating threshold |
| host_mode | input | 1 | 1 = host-register control, 0 = pin control |
| lb_pin_a | input | 1 | Remote loopback control pin |
| lb_pin_b | input | 1 | Local loopback control pin |
| wr_stb | input | 1 | Host control-register write strobe |
| wr_lb_a | input | 1 | Remote loopback bit of the host write |
| wr_lb_b | input | 1 | Local loopback bit of the host write |
| ref_clk_ok | input | 1 | Reference clock activity is present |
| cal_done | input | 1 | Delay-line calibration has completed |
| reg_clear | output | 1 | One-cycle pulse that clears the control register |
| los_set | output | 1 | One-cycle pulse that forces loss-of-signal high |
| osc_centre | output | 1 | Hold the oscillator at its centre frequency |
| cal_busy | output | 1 | Calibration phase in progress |
| cal_timeout | output | 1 | Sticky: last calibration hit its time limit |

## Verification
A request width counter that is off by one shows up at the release cycle. A hold of exactly `REQ_MIN_CYC` cycles would not fire, or `REQ_MIN_CYC - 1` would fire, and either is visible on `reg_clear` one cycle after the pins drop. Stimulus therefore mixes random widths with widths on both sides of the limit. A wrong wait or timeout count moves the rising edge of `reg_clear` or the falling edge of `cal_busy` by whole cycles, and the bench measures both exactly. A sequencer stuck in the wrong phase shows on `osc_centre` or `cal_busy` in the first cycle after the stimulus that should have moved it.

// File: rtl/li_rstseq_pkg.sv
// Package: shared phase encoding for the reset and calibration sequencer.
// Assumes: nothing; holds only types.
package li_rstseq_pkg;

    // Sequencer phases, one-hot-free binary encoding.
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,  // no power, oscillator held centred
        PH_WAIT   = 3'd1,  // power-up settling delay
        PH_CLEAR  = 3'd2,  // one-cycle reset application
        PH_CAL    = 3'd3,  // calibration in progress
        PH_ACTIVE = 3'd4   // normal operation
    } phase_t;

endpackage

// File: rtl/li_rstseq_pin_detect.sv
// Module: detects a pin-mode reset request on two loopback control pins.
// Counts consecutive cycles with both pins high (saturating at REQ_MIN_CYC)
// and emits a one-cycle request in the cycle where the joint-high condition
// ends, if the count had reached the minimum.
// Assumes: pins are already synchronous to clk; host mode disables detection.
module li_rstseq_pin_detect #(
    parameter int REQ_MIN_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic pin_a,
    input  logic pin_b,
    output logic fire
);

    localparam int CW = $clog2(REQ_MIN_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(REQ_MIN_CYC);

    logic          both_hi;
    logic [CW-1:0] width_cnt;

    assign both_hi = enable && pin_a && pin_b;

    // Width counter: advance while both pins are high, restart otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_cnt <= '0;
        end else if (both_hi) begin
            if (width_cnt != CNT_MAX) begin
                width_cnt <= width_cnt + 1'b1;
            end
        end else begin
            width_cnt <= '0;
        end
    end

    // Release-edge request: condition ended after a long enough hold.
    assign fire = enable && !both_hi && (width_cnt == CNT_MAX);

    // R3: a request only appears in the cycle the joint-high condition ended
    p_fire_on_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (!(pin_a && pin_b) && $past(pin_a && pin_b)));

    // R4: any cycle without both pins high restarts the width count
    p_width_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !both_hi |=> (width_cnt == '0));

endmodule

// File: rtl/li_rstseq_phase_timer.sv
// Module: cycle counter for one sequencer phase.
// Counts from zero while 'run' is high and clears when it is low; 'last'
// marks the LIMIT_CYC-th cycle of an uninterrupted run.
// Assumes: LIMIT_CYC >= 1.
module li_rstseq_phase_timer #(
    parameter int LIMIT_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);

    localparam int TW = $clog2(LIMIT_CYC + 1);
    localparam logic [TW-1:0] LAST_VAL = TW'(LIMIT_CYC - 1);

    logic [TW-1:0] count;

    // Phase counter: free-run while the phase lasts, hold at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            count <= '0;
        end else if (count != LAST_VAL) begin
            count <= count + 1'b1;
        end
    end

    assign last = run && (count == LAST_VAL);

    // R8: the counter never moves outside a running phase
    p_timer_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (count == '0));

endmodule

// File: rtl/li_rstseq_fsm.sv
// Module: phase sequencer. Walks idle -> wait -> clear -> calibrate ->
// active, re-enters clear on any reset request, and drops to idle when
// power is lost. Keeps the sticky calibration-timeout flag.
// Assumes: reset requests are single-cycle pulses; timers are cleared
// whenever their phase is not current.
module li_rstseq_fsm
    import li_rstseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pwr_good,
    input  logic   reset_req,
    input  logic   wait_last,
    input  logic   cal_last,
    input  logic   ref_clk_ok,
    input  logic   cal_done,
    output phase_t phase,
    output logic   timeout_flag
);

    phase_t phase_nxt;
    logic   done_ok;

    assign done_ok = cal_done && ref_clk_ok;

    // Next-phase selection: power loss wins, then reset requests.
    always_comb begin
        phase_nxt = phase;
        if (!pwr_good) begin
            phase_nxt = PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE:   phase_nxt = PH_WAIT;
                PH_WAIT:   phase_nxt = (reset_req || wait_last) ? PH_CLEAR : PH_WAIT;
                PH_CLEAR:  phase_nxt = reset_req ? PH_CLEAR : PH_CAL;
                PH_CAL: begin
                    if (reset_req)                 phase_nxt = PH_CLEAR;
                    else if (done_ok || cal_last)  phase_nxt = PH_ACTIVE;
                    else                           phase_nxt = PH_CAL;
                end
                PH_ACTIVE: phase_nxt = reset_req ? PH_CLEAR : PH_ACTIVE;
                default:   phase_nxt = PH_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nxt;
        end
    end

    // Sticky timeout: set on an expired calibration, cleared at restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timeout_flag <= 1'b0;
        end else if (phase == PH_CLEAR || phase == PH_IDLE) begin
            timeout_flag <= 1'b0;
        end else if (phase == PH_CAL && pwr_good && !reset_req
                     && !done_ok && cal_last) begin
            timeout_flag <= 1'b1;
        end
    end

    // R9: loss of power always returns the sequencer to idle
    p_idle_on_power_loss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (phase == PH_IDLE));

    // R6: a clear phase lasts one cycle unless re-requested
    p_clear_then_cal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CLEAR && pwr_good && !reset_req) |=> (phase == PH_CAL));

    // R8: timeout only rises at the end of a calibration phase
    p_timeout_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_flag) |-> ($past(phase) == PH_CAL && phase == PH_ACTIVE));

    // R7: a done without reference activity does not end calibration early
    p_done_needs_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CAL && pwr_good && !reset_req && !ref_clk_ok && !cal_last)
        |=> (phase == PH_CAL));

endmodule

// File: rtl/li_reset_sequencer.sv
// Module: top of the line interface reset and calibration sequencer.
// Merges pin-mode and host-mode reset requests, times the power-up wait and
// calibration limit, and decodes the phase into the control outputs.
// Assumes: all inputs are synchronous to clk; durations in clk cycles.
module li_reset_sequencer
    import li_rstseq_pkg::*;
#(
    parameter int REQ_MIN_CYC   = 25,
    parameter int PWR_DELAY_CYC = 1250000,
    parameter int CAL_LIMIT_CYC = 2500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic host_mode,
    input  logic lb_pin_a,
    input  logic lb_pin_b,
    input  logic wr_stb,
    input  logic wr_lb_a,
    input  logic wr_lb_b,
    input  logic ref_clk_ok,
    input  logic cal_done,
    output logic reg_clear,
    output logic los_set,
    output logic osc_centre,
    output logic cal_busy,
    output logic cal_timeout
);

    phase_t phase;
    logic   pin_fire;
    logic   host_fire;
    logic   reset_req;
    logic   wait_last;
    logic   cal_last;

    li_rstseq_pin_detect #(
        .REQ_MIN_CYC (REQ_MIN_CYC)
    ) u_pin_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (!host_mode),
        .pin_a  (lb_pin_a),
        .pin_b  (lb_pin_b),
        .fire   (pin_fire)
    );

    // Host request: one write carrying both loopback bits.
    assign host_fire = host_mode && wr_stb && wr_lb_a && wr_lb_b;
    assign reset_req = pin_fire || host_fire;

    li_rstseq_phase_timer #(
        .LIMIT_CYC (PWR_DELAY_CYC)
    ) u_wait_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (phase == PH_WAIT),
        .last  (wait_last)
    );

    li_rstseq_phase_timer #(
        .LIMIT_CYC (CAL_LIMIT_CYC)
    ) u_cal_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (phase == PH_CAL),
        .last  (cal_last)
    );

    li_rstseq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_good     (pwr_good),
        .reset_req    (reset_req),
        .wait_last    (wait_last),
        .cal_last     (cal_last),
        .ref_clk_ok   (ref_clk_ok),
        .cal_done     (cal_done),
        .phase        (phase),
        .timeout_flag (cal_timeout)
    );

    // Output decode from the registered phase.
    assign reg_clear  = (phase == PH_CLEAR);
    assign los_set    = (phase == PH_CLEAR);
    assign osc_centre = (phase == PH_IDLE) || (phase == PH_WAIT) || (phase == PH_CLEAR);
    assign cal_busy   = (phase == PH_CAL);

    // R6: a clear pulse is followed by calibration while power holds
    p_busy_after_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_clear && pwr_good && !reset_req) |=> (cal_busy && !reg_clear));

    // R5: a host write in pin mode never clears the registers
    p_pin_mode_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_mode && wr_stb && !pin_fire && !reg_clear && !wait_last)
        |=> !reg_clear);

    // R1: outputs at the first cycle after reset
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!cal_busy && !reg_clear && !cal_timeout && osc_centre));

endmodule

// File: tb/test_li_reset_sequencer.sv
// Bench: directed corner cases plus seeded random request widths.
module test_li_reset_sequencer;

    localparam int MINW = 6;
    localparam int DLY  = 20;
    localparam int LIM  = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0, host_mode = 1'b0, lb_pin_a = 1'b0, lb_pin_b = 1'b0;
    logic wr_stb = 1'b0, wr_lb_a = 1'b0, wr_lb_b = 1'b0;
    logic ref_clk_ok = 1'b1, cal_done = 1'b0;
    logic reg_clear, los_set, osc_centre, cal_busy, cal_timeout;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;  // 125 MHz

    li_reset_sequencer #(
        .REQ_MIN_CYC   (MINW),
        .PWR_DELAY_CYC (DLY),
        .CAL_LIMIT_CYC (LIM)
    ) i_li_reset_sequencer (
        .clk (clk), .rst_n (rst_n), .pwr_good (pwr_good), .host_mode (host_mode),
        .lb_pin_a (lb_pin_a), .lb_pin_b (lb_pin_b), .wr_stb (wr_stb),
        .wr_lb_a (wr_lb_a), .wr_lb_b (wr_lb_b), .ref_clk_ok (ref_clk_ok),
        .cal_done (cal_done), .reg_clear (reg_clear), .los_set (los_set),
        .osc_centre (osc_centre), .cal_busy (cal_busy), .cal_timeout (cal_timeout)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected outcome of a joint-high hold of w cycles (R3, R4).
    function automatic int fire_expected(input int w);
        return (w >= MINW) ? 1 : 0;
    endfunction

    task automatic complete_cal();
        cal_done = 1'b1;
        tick();
        cal_done = 1'b0;
        chk("R7 busy drops after done", cal_busy, 0);
    endtask

    // Hold both pins for w cycles, release, and check the outcome.
    task automatic pin_hold(input int w, input int exp_fire, input string req);
        lb_pin_a = 1'b1; lb_pin_b = 1'b1;
        for (int i = 0; i < w; i++) begin
            tick();
            if (reg_clear) chk({req, " no fire while held"}, 1, 0);
        end
        lb_pin_a = 1'b0; lb_pin_b = 1'b0;
        tick();
        chk(req, reg_clear, exp_fire);
        if (reg_clear) begin
            chk("R6 los with clear", los_set, 1);
            tick();
            chk("R6 busy after clear", cal_busy, 1);
            complete_cal();
        end
    endtask

    initial begin
        int k;
        void'($urandom(32'd4242));

        // R1 reset state
        repeat (3) tick();
        chk("R1 busy", cal_busy, 0);
        chk("R1 clear", reg_clear, 0);
        chk("R1 los", los_set, 0);
        chk("R1 osc", osc_centre, 1);
        chk("R1 timeout", cal_timeout, 0);
        rst_n = 1'b1;
        tick(); tick();
        chk("R2 idle osc", osc_centre, 1);

        // R2 power-up wait
        pwr_good = 1'b1;
        k = 0;
        do begin
            tick(); k++;
            if (!reg_clear) chk("R2 osc during wait", osc_centre, 1);
        end while (!reg_clear && k < 1000);
        chk("R2 wait length", k, DLY + 1);
        chk("R6 los set", los_set, 1);
        chk("R6 osc in clear", osc_centre, 1);
        tick();
        chk("R6 clear is one cycle", reg_clear, 0);
        chk("R6 busy", cal_busy, 1);
        chk("R6 osc released", osc_centre, 0);

        // R7 done ignored without reference
        ref_clk_ok = 1'b0; cal_done = 1'b1;
        tick(); tick();
        chk("R7 done ignored without ref", cal_busy, 1);
        cal_done = 1'b0; ref_clk_ok = 1'b1;
        complete_cal();
        chk("R8 no timeout", cal_timeout, 0);

        // R3 / R4 directed boundaries
        pin_hold(MINW, 1, "R3 exact minimum");
        pin_hold(MINW - 1, 0, "R4 one short");
        pin_hold(3 * MINW, 1, "R3 long hold");

        // R4 restart when one pin drops
        lb_pin_a = 1'b1; lb_pin_b = 1'b1;
        repeat (MINW - 1) tick();
        lb_pin_b = 1'b0; tick();
        lb_pin_b = 1'b1;
        repeat (MINW - 1) tick();
        lb_pin_a = 1'b0; lb_pin_b = 1'b0; tick();
        chk("R4 width restart", reg_clear, 0);

        // R4 single pin
        lb_pin_a = 1'b1;
        repeat (3 * MINW) tick();
        lb_pin_a = 1'b0; tick();
        chk("R4 single pin", reg_clear, 0);

        // R3 / R4 random widths
        for (int i = 0; i < 12; i++) begin
            int w;
            w = 1 + int'($urandom % (2 * MINW));
            pin_hold(w, fire_expected(w), "R3/R4 random width");
            repeat (1 + ($urandom % 3)) tick();
        end

        // R5 pins ignored in host mode
        host_mode = 1'b1;
        lb_pin_a = 1'b1; lb_pin_b = 1'b1;
        repeat (2 * MINW) tick();
        lb_pin_a = 1'b0; lb_pin_b = 1'b0; tick();
        chk("R5 pins ignored in host mode", reg_clear, 0);

        // R5 single-bit host write
        wr_stb = 1'b1; wr_lb_a = 1'b1; wr_lb_b = 1'b0; tick();
        wr_stb = 1'b0; wr_lb_a = 1'b0;
        chk("R5 single bit write", reg_clear, 0);

        // R5 host write of both bits
        wr_stb = 1'b1; wr_lb_a = 1'b1; wr_lb_b = 1'b1; tick();
        wr_stb = 1'b0; wr_lb_a = 1'b0; wr_lb_b = 1'b0;
        chk("R5 host reset", reg_clear, 1);
        tick();
        chk("R5 busy after host reset", cal_busy, 1);
        complete_cal();

        // R5 host write in pin mode
        host_mode = 1'b0;
        wr_stb = 1'b1; wr_lb_a = 1'b1; wr_lb_b = 1'b1; tick();
        wr_stb = 1'b0; wr_lb_a = 1'b0; wr_lb_b = 1'b0;
        chk("R5 write in pin mode", reg_clear, 0);

        // R8 timeout
        pin_hold(MINW, 1, "R3 before timeout");  // completes normally
        lb_pin_a = 1'b1; lb_pin_b = 1'b1;
        repeat (MINW) tick();
        lb_pin_a = 1'b0; lb_pin_b = 1'b0; tick();
        chk("R8 reset started", reg_clear, 1);
        k = 0;
        tick();
        while (cal_busy && k < 1000) begin
            k++; tick();
        end
        chk("R8 busy length", k, LIM);
        chk("R8 timeout raised", cal_timeout, 1);
        repeat (5) tick();
        chk("R8 timeout sticky", cal_timeout, 1);
        host_mode = 1'b1;
        wr_stb = 1'b1; wr_lb_a = 1'b1; wr_lb_b = 1'b1; tick();
        wr_stb = 1'b0; wr_lb_a = 1'b0; wr_lb_b = 1'b0;
        tick();
        chk("R8 timeout cleared at restart", cal_timeout, 0);

        // R9 power loss during calibration
        pwr_good = 1'b0; tick();
        chk("R9 busy off", cal_busy, 0);
        chk("R9 osc centre", osc_centre, 1);
        pwr_good = 1'b1;
        k = 0;
        do begin
            tick(); k++;
        end while (!reg_clear && k < 1000);
        chk("R9/R2 wait after power return", k, DLY + 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule